// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block takes a memory address arriving on one side of a bridge and works out where it should go on the other side. It holds a small set of programmable windows. Each window has a base, a mask of offset bits, a translation base, an optional offset cap and a control word. The incoming address is compared against every enabled window. The lowest-numbered window that matches decides the result.

A window can work in one of three ways. In direct mode, the masked offset bits are kept and every bit above them comes from the translation register. In table mode, a 6-bit field is taken from the address at a programmable bit position. That field picks one of 64 translated bases, and the address bits below the field pass through unchanged. In register-pass mode, the window reaches the block's own control space, and the address leaves untranslated. A narrow window uses only the low 32-bit halves of its registers. A wide window uses both halves as one 64-bit pair.

Configuration is written through a simple word-wide register port. The decode is combinational, and its outcome is captured in a register stage. The response therefore appears one cycle after the request.

Top module: `atu_top`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_reject are 0. Every window is disabled and every table entry is 0, so any request reports a miss.
- R2: A request presented with req_valid=1 produces rsp_valid=1 on the next cycle only. With no request, rsp_valid, rsp_hit and rsp_reject are 0.
- R3: Let M be a window's offset mask. An address A matches the window when (A & ~M) equals (base & ~M). In direct mode (control [1:0]=1) the forwarded address is (xlat & ~M) | (A & M), so the low bits of the translation register are ignored.
- R4: A narrow window (control bit 2 = 0) uses only the low 32 bits of base, mask and translation, and never matches an address with nonzero bits [63:32]. A wide window (bit 2 = 1) uses all 64 bits, which lets a high window be moved below 4 GiB.
- R5: In table mode (control [1:0]=2) with position p (control [12:8]), the index is A[p+5:p]. The forwarded address is {32'b0, (entry & ~(2^p-1)) | (A[31:0] & (2^p-1))}.
- R6: Changing p moves the index field and the width of the passed-through offset. With p=0 the entry is forwarded whole.
- R7: When control bit 3 is set and the offset (A & M) is at or above the 32-bit limit register, the response has rsp_reject=1, reason 2 and rsp_addr=0. An offset of limit-1 is still forwarded.
- R8: In register-pass mode (control [1:0]=3), a matching address is forwarded unchanged and rsp_csr=1.
- R9: When no enabled window matches, the response has rsp_reject=1, reason 1, rsp_hit=0 and rsp_addr=0. A forwarded address carries reason 0.
- R10: When several windows match, the lowest-numbered one supplies the result and rsp_win. A window with mode 0 never matches.
- R11: Configuration address bit 7 = 1 writes table entry cfg_addr[5:0]. Bit 7 = 0 writes window cfg_addr[6:3], field cfg_addr[2:0], with fields as follows: 0/1 base low/high, 2/3 mask low/high, 4/5 translation low/high, 6 limit, 7 control. A write takes effect for requests made in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Incoming address |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Address forwarded |
| rsp_reject | output | 1 | Address not forwarded (miss or over limit) |
| rsp_reason | output | 2 | 0 none, 1 no window, 2 over limit |
| rsp_win | output | WIN_W | Index of the deciding window |
| rsp_csr | output | 1 | Forwarded through a register-pass window |
| rsp_addr | output | 64 | Forwarded address, 0 on reject |

## Verification
The bench probes the exact top and bottom edges of each window and the offset at limit-1 and at limit. A design that compared with the wrong boundary or the wrong inequality would forward one address too many or too few. Narrow windows are hit with upper address bits set, which catches a design that ignores bits [63:32]. Table windows are run at several index positions, including 0, which exposes a shifted index or a leaking translation bit. Overlapping windows are checked both before and after the winner is disabled, which exposes reversed priority or a disabled window that still matches.

// File: rtl/atu_pkg.sv
package atu_pkg;

    localparam int ADDR_W    = 64;
    localparam int HALF_W    = 32;
    localparam int TBL_IDX_W = 6;
    localparam int TBL_DEPTH = 1 << TBL_IDX_W;
    localparam int POS_W     = 5;
    localparam int CFG_AW    = 8;
    localparam int FLD_W     = 3;
    localparam int SLOT_W    = CFG_AW - 1 - FLD_W;

    localparam logic [FLD_W-1:0] FLD_BASE_LO = 3'd0;
    localparam logic [FLD_W-1:0] FLD_BASE_HI = 3'd1;
    localparam logic [FLD_W-1:0] FLD_MASK_LO = 3'd2;
    localparam logic [FLD_W-1:0] FLD_MASK_HI = 3'd3;
    localparam logic [FLD_W-1:0] FLD_XLAT_LO = 3'd4;
    localparam logic [FLD_W-1:0] FLD_XLAT_HI = 3'd5;
    localparam logic [FLD_W-1:0] FLD_LIMIT   = 3'd6;
    localparam logic [FLD_W-1:0] FLD_CTRL    = 3'd7;

    typedef enum logic [1:0] {
        WM_OFF    = 2'd0,
        WM_DIRECT = 2'd1,
        WM_TABLE  = 2'd2,
        WM_CSR    = 2'd3
    } win_mode_e;

    typedef enum logic [1:0] {
        RS_NONE       = 2'd0,
        RS_NO_WINDOW  = 2'd1,
        RS_OVER_LIMIT = 2'd2
    } reason_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] xlat;
        logic [HALF_W-1:0] limit;
        win_mode_e         mode;
        logic              wide;
        logic              lim_en;
        logic [POS_W-1:0]  tbl_pos;
    } win_cfg_t;

    typedef struct packed {
        logic              match;
        logic              over;
        logic              csr;
        logic [ADDR_W-1:0] xaddr;
    } win_res_t;

    typedef struct packed {
        logic              hit;
        logic              reject;
        reason_e           reason;
        logic              csr;
        logic [ADDR_W-1:0] addr;
    } xlat_out_t;

    function automatic logic [ADDR_W-1:0] widen(input logic [ADDR_W-1:0] v, input logic wide);
        return wide ? v : {{(ADDR_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] low_ones(input logic [POS_W-1:0] pos);
        return (ADDR_W'(1) << pos) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/atu_cfg_regs.sv
module atu_cfg_regs
    import atu_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [CFG_AW-1:0]                   addr,
    input  logic [HALF_W-1:0]                   wdata,
    output win_cfg_t [NUM_WIN-1:0]              win_cfg,
    output logic [TBL_DEPTH-1:0][HALF_W-1:0]    tbl
);

    logic               tbl_sel;
    logic [SLOT_W-1:0]  slot;
    logic [FLD_W-1:0]   fld;
    logic [TBL_IDX_W-1:0] tbl_idx;

    assign tbl_sel = addr[CFG_AW-1];
    assign slot    = addr[CFG_AW-2 -: SLOT_W];
    assign fld     = addr[FLD_W-1:0];
    assign tbl_idx = addr[TBL_IDX_W-1:0];

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            win_cfg_t r;
            logic     sel_w;
            assign sel_w = we && !tbl_sel && (slot == SLOT_W'(w));

            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= '0;
                end else if (sel_w) begin
                    case (fld)
                        FLD_BASE_LO: r.base[HALF_W-1:0]      <= wdata;
                        FLD_BASE_HI: r.base[ADDR_W-1:HALF_W] <= wdata;
                        FLD_MASK_LO: r.mask[HALF_W-1:0]      <= wdata;
                        FLD_MASK_HI: r.mask[ADDR_W-1:HALF_W] <= wdata;
                        FLD_XLAT_LO: r.xlat[HALF_W-1:0]      <= wdata;
                        FLD_XLAT_HI: r.xlat[ADDR_W-1:HALF_W] <= wdata;
                        FLD_LIMIT:   r.limit                 <= wdata;
                        default: begin
                            r.mode    <= win_mode_e'(wdata[1:0]);
                            r.wide    <= wdata[2];
                            r.lim_en  <= wdata[3];
                            r.tbl_pos <= wdata[8 +: POS_W];
                        end
                    endcase
                end
            end

            assign win_cfg[w] = r;
        end

        for (genvar t = 0; t < TBL_DEPTH; t++) begin : g_tbl
            logic [HALF_W-1:0] entry;
            always_ff @(posedge clk) begin
                if (rst) begin
                    entry <= '0;
                end else if (we && tbl_sel && (tbl_idx == TBL_IDX_W'(t))) begin
                    entry <= wdata;
                end
            end
            assign tbl[t] = entry;
        end
    endgenerate

endmodule

// File: rtl/atu_win_match.sv
module atu_win_match
    import atu_pkg::*;
(
    input  win_cfg_t                            cfg,
    input  logic [TBL_DEPTH-1:0][HALF_W-1:0]    tbl,
    input  logic [ADDR_W-1:0]                   addr,
    output win_res_t                            res
);

    logic [ADDR_W-1:0]    m;
    logic [ADDR_W-1:0]    b;
    logic [ADDR_W-1:0]    x;
    logic [ADDR_W-1:0]    off;
    logic [ADDR_W-1:0]    keep;
    logic [ADDR_W-1:0]    tbl_base;
    logic [TBL_IDX_W-1:0] idx;
    logic                 upper_ok;

    always_comb begin
        m        = widen(cfg.mask, cfg.wide);
        b        = widen(cfg.base, cfg.wide);
        x        = widen(cfg.xlat, cfg.wide);
        upper_ok = cfg.wide || (addr[ADDR_W-1:HALF_W] == '0);
        off      = addr & m;
        idx      = TBL_IDX_W'(addr >> cfg.tbl_pos);
        keep     = low_ones(cfg.tbl_pos);
        tbl_base = {{(ADDR_W-HALF_W){1'b0}}, tbl[idx]};

        res.match = (cfg.mode != WM_OFF) && upper_ok && (((addr ^ b) & ~m) == '0);
        res.over  = cfg.lim_en && (off >= {{(ADDR_W-HALF_W){1'b0}}, cfg.limit});
        res.csr   = (cfg.mode == WM_CSR);

        case (cfg.mode)
            WM_DIRECT: res.xaddr = (x & ~m) | off;
            WM_TABLE:  res.xaddr = (tbl_base & ~keep) | (addr & keep);
            WM_CSR:    res.xaddr = addr;
            default:   res.xaddr = '0;
        endcase
    end

endmodule

// File: rtl/atu_select.sv
module atu_select
    import atu_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 2
) (
    input  win_res_t [NUM_WIN-1:0] res,
    output xlat_out_t              pick,
    output logic [WIN_W-1:0]       win
);

    always_comb begin
        pick.hit    = 1'b0;
        pick.reject = 1'b1;
        pick.reason = RS_NO_WINDOW;
        pick.csr    = 1'b0;
        pick.addr   = '0;
        win         = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (res[i].match) begin
                pick.hit    = !res[i].over;
                pick.reject = res[i].over;
                pick.reason = res[i].over ? RS_OVER_LIMIT : RS_NONE;
                pick.csr    = !res[i].over && res[i].csr;
                pick.addr   = res[i].over ? '0 : res[i].xaddr;
                win         = WIN_W'(i);
            end
        end
    end

endmodule

// File: rtl/atu_top.sv
module atu_top
    import atu_pkg::*;
#(
    parameter  int NUM_WIN = 4,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_reject,
    output logic [1:0]        rsp_reason,
    output logic [WIN_W-1:0]  rsp_win,
    output logic              rsp_csr,
    output logic [63:0]       rsp_addr
);

    win_cfg_t [NUM_WIN-1:0]             win_cfg;
    logic [TBL_DEPTH-1:0][HALF_W-1:0]   tbl;
    win_res_t [NUM_WIN-1:0]             res;
    xlat_out_t                          pick;
    logic [WIN_W-1:0]                   pick_win;

    atu_cfg_regs #(.NUM_WIN(NUM_WIN)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .win_cfg (win_cfg),
        .tbl     (tbl)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
            atu_win_match u_match (
                .cfg  (win_cfg[w]),
                .tbl  (tbl),
                .addr (req_addr),
                .res  (res[w])
            );
        end
    endgenerate

    atu_select #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_sel (
        .res  (res),
        .pick (pick),
        .win  (pick_win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_reject <= 1'b0;
            rsp_reason <= RS_NONE;
            rsp_win    <= '0;
            rsp_csr    <= 1'b0;
            rsp_addr   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= req_valid && pick.hit;
            rsp_reject <= req_valid && pick.reject;
            rsp_reason <= req_valid ? pick.reason : RS_NONE;
            rsp_win    <= req_valid ? pick_win : '0;
            rsp_csr    <= req_valid && pick.csr;
            rsp_addr   <= req_valid ? pick.addr : '0;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_reject));

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_reject));

    // R7
    reject_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_reject |-> (rsp_addr == '0 && rsp_reason != RS_NONE));

    // R8
    csr_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_csr |-> (rsp_hit && rsp_addr == $past(req_addr)));

endmodule

// File: tb/atu_top_tb.sv
`timescale 1ns/1ps
module atu_top_tb;

    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        rsp_valid, rsp_hit, rsp_reject, rsp_csr;
    logic [1:0]  rsp_reason;
    logic [1:0]  rsp_win;
    logic [63:0] rsp_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [63:0] sb_base [NW];
    logic [63:0] sb_mask [NW];
    logic [63:0] sb_xl   [NW];
    logic [31:0] sb_lim  [NW];
    logic [1:0]  sb_mode [NW];
    logic        sb_wide [NW];
    logic        sb_le   [NW];
    logic [4:0]  sb_pos  [NW];
    logic [31:0] sb_tbl  [64];

    always #2 clk = ~clk;

    atu_top #(.NUM_WIN(NW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_reject(rsp_reject), .rsp_reason(rsp_reason), .rsp_win(rsp_win),
        .rsp_csr(rsp_csr), .rsp_addr(rsp_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input int w, input logic [63:0] base, input logic [63:0] mask,
                           input logic [63:0] xl, input logic [31:0] lim, input logic [1:0] mode,
                           input logic wide, input logic le, input logic [4:0] pos);
        logic [7:0] a;
        a = {1'b0, 4'(w), 3'd0};
        cfg_write(a | 8'd0, base[31:0]);
        cfg_write(a | 8'd1, base[63:32]);
        cfg_write(a | 8'd2, mask[31:0]);
        cfg_write(a | 8'd3, mask[63:32]);
        cfg_write(a | 8'd4, xl[31:0]);
        cfg_write(a | 8'd5, xl[63:32]);
        cfg_write(a | 8'd6, lim);
        cfg_write(a | 8'd7, 32'(mode) | (32'(wide) << 2) | (32'(le) << 3) | (32'(pos) << 8));
        sb_base[w] = base; sb_mask[w] = mask; sb_xl[w] = xl; sb_lim[w] = lim;
        sb_mode[w] = mode; sb_wide[w] = wide; sb_le[w] = le; sb_pos[w] = pos;
    endtask

    task automatic tbl_write(input int i, input logic [31:0] d);
        cfg_write(8'h80 | 8'(i), d);
        sb_tbl[i] = d;
    endtask

    task automatic model(input logic [63:0] a, output logic e_hit, output logic e_rej,
                         output logic [1:0] e_rsn, output logic [1:0] e_win,
                         output logic e_csr, output logic [63:0] e_addr);
        logic [63:0] m, b, x, keep;
        logic [5:0]  idx;
        bit found;
        found = 0;
        e_hit = 0; e_rej = 1; e_rsn = 2'd1; e_win = 0; e_csr = 0; e_addr = 0;
        for (int i = 0; i < NW; i++) begin
            m = sb_wide[i] ? sb_mask[i] : {32'b0, sb_mask[i][31:0]};
            b = sb_wide[i] ? sb_base[i] : {32'b0, sb_base[i][31:0]};
            x = sb_wide[i] ? sb_xl[i]   : {32'b0, sb_xl[i][31:0]};
            if (!found && sb_mode[i] != 2'd0 && (sb_wide[i] || a[63:32] == 0)
                && ((a & ~m) == (b & ~m))) begin
                found = 1;
                e_win = 2'(i);
                if (sb_le[i] && ((a & m) >= {32'b0, sb_lim[i]})) begin
                    e_rsn = 2'd2;
                end else begin
                    e_hit = 1; e_rej = 0; e_rsn = 2'd0;
                    case (sb_mode[i])
                        2'd1: e_addr = (x & ~m) | (a & m);
                        2'd2: begin
                            idx    = 6'(a >> sb_pos[i]);
                            keep   = (64'd1 << sb_pos[i]) - 64'd1;
                            e_addr = ({32'b0, sb_tbl[idx]} & ~keep) | (a & keep);
                        end
                        default: begin e_addr = a; e_csr = 1; end
                    endcase
                end
            end
        end
    endtask

    task automatic do_req(input logic [63:0] a, input string req);
        logic e_hit, e_rej, e_csr;
        logic [1:0] e_rsn, e_win;
        logic [63:0] e_addr;
        bit ok;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        model(a, e_hit, e_rej, e_rsn, e_win, e_csr, e_addr);
        ok = rsp_valid && rsp_hit == e_hit && rsp_reject == e_rej && rsp_reason == e_rsn
             && rsp_csr == e_csr && rsp_addr == e_addr
             && (e_rsn == 2'd1 || rsp_win == e_win);
        chk(ok, req, {rsp_hit, rsp_reject, rsp_reason, rsp_csr, rsp_win, rsp_addr[56:0]},
                     {e_hit, e_rej, e_rsn, e_csr, e_win, e_addr[56:0]});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, base, mask;
        int sz, pos;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NW; i++) begin
            sb_base[i] = 0; sb_mask[i] = 0; sb_xl[i] = 0; sb_lim[i] = 0;
            sb_mode[i] = 0; sb_wide[i] = 0; sb_le[i] = 0; sb_pos[i] = 0;
        end
        for (int i = 0; i < 64; i++) sb_tbl[i] = 0;
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; req_valid = 0; req_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!rsp_valid && !rsp_hit && !rsp_reject, "R1", {61'b0, rsp_valid, rsp_hit, rsp_reject}, 0);
        do_req(64'h1234_5678, "R1");
        chk(rsp_reason == 2'd1, "R1", 64'(rsp_reason), 1);

        // R3 direct narrow window, translation low bits ignored
        set_win(0, 64'h1000_0000, 64'h000F_FFFF, 64'h8001_2345, 0, 2'd1, 0, 0, 0);
        do_req(64'h1003_4567, "R3");
        chk(rsp_addr == 64'h8003_4567, "R3", rsp_addr, 64'h8003_4567);
        // R2 response lasts one cycle only
        @(negedge clk);
        chk(!rsp_valid && !rsp_hit && !rsp_reject, "R2", {61'b0, rsp_valid, rsp_hit, rsp_reject}, 0);
        do_req(64'h100F_FFFF, "R3");
        do_req(64'h1000_0000, "R3");
        do_req(64'h1010_0000, "R9");
        chk(rsp_reason == 2'd1 && rsp_addr == 0, "R9", rsp_addr, 0);
        do_req(64'h0FFF_FFFF, "R9");
        // R4 narrow window ignores high-address aliases
        do_req(64'h1_1003_4567, "R4");
        chk(rsp_reject, "R4", 64'(rsp_reject), 1);

        // R4 wide window moved below 4 GiB
        set_win(1, 64'h20_0000_0000, 64'h0000_0000_FFFF_FFFF, 64'h0, 0, 2'd1, 1, 0, 0);
        do_req(64'h20_1234_5678, "R4");
        chk(rsp_addr == 64'h1234_5678 && rsp_win == 2'd1, "R4", rsp_addr, 64'h1234_5678);
        do_req(64'h21_0000_0000, "R4");

        // R5 table window, index at bit 14
        for (int i = 0; i < 64; i++) tbl_write(i, $urandom);
        tbl_write(5, 32'hABCD_1234);
        set_win(2, 64'h4000_0000, 64'h000F_FFFF, 0, 0, 2'd2, 0, 0, 5'd14);
        do_req(64'h4000_0000 | (64'd5 << 14) | 64'h1A5A, "R5");
        chk(rsp_addr == 64'hABCD_1A5A, "R5", rsp_addr, 64'hABCD_1A5A);
        do_req(64'h400F_FFFF, "R5");
        // R6 other index positions
        set_win(2, 64'h4000_0000, 64'h000F_FFFF, 0, 0, 2'd2, 0, 0, 5'd12);
        do_req(64'h4000_0000 | (64'd5 << 12) | 64'h0F0F, "R6");
        chk(rsp_addr == 64'hABCD_1F0F, "R6", rsp_addr, 64'hABCD_1F0F);
        set_win(2, 64'h4000_0000, 64'h000F_FFFF, 0, 0, 2'd2, 0, 0, 5'd0);
        do_req(64'h4000_0005, "R6");
        chk(rsp_addr == 64'hABCD_1234, "R6", rsp_addr, 64'hABCD_1234);

        // R7 limit cap on window 0
        set_win(0, 64'h1000_0000, 64'h000F_FFFF, 64'h8000_0000, 32'h8_0000, 2'd1, 0, 1, 0);
        do_req(64'h1007_FFFF, "R7");
        chk(rsp_hit && rsp_addr == 64'h8007_FFFF, "R7", rsp_addr, 64'h8007_FFFF);
        do_req(64'h1008_0000, "R7");
        chk(rsp_reject && rsp_reason == 2'd2 && rsp_addr == 0, "R7", 64'(rsp_reason), 2);
        do_req(64'h100F_FFFF, "R7");

        // R8 register-pass window
        set_win(3, 64'h5000_0000, 64'h0000_0FFF, 64'hDEAD_0000, 0, 2'd3, 0, 0, 0);
        do_req(64'h5000_0ABC, "R8");
        chk(rsp_csr && rsp_addr == 64'h5000_0ABC, "R8", rsp_addr, 64'h5000_0ABC);

        // R10 overlap: window 3 covers window 0's range
        set_win(3, 64'h1000_0000, 64'h00FF_FFFF, 64'h9000_0000, 0, 2'd1, 0, 0, 0);
        do_req(64'h1001_0000, "R10");
        chk(rsp_win == 2'd0, "R10", 64'(rsp_win), 0);
        set_win(0, 64'h1000_0000, 64'h000F_FFFF, 64'h8000_0000, 0, 2'd0, 0, 0, 0);
        do_req(64'h1001_0000, "R10");
        chk(rsp_win == 2'd3 && rsp_addr == 64'h9001_0000, "R10", rsp_addr, 64'h9001_0000);

        // R11 write to window slot beyond NUM_WIN does not disturb existing windows
        cfg_write(8'h47, 32'h1);
        do_req(64'h1001_0000, "R11");

        // random phase
        for (int round = 0; round < 8; round++) begin
            for (int w = 0; w < NW; w++) begin
                logic wide;
                wide = (w == 1);
                sz   = wide ? 20 + int'($urandom % 21) : 12 + int'($urandom % 13);
                mask = (64'd1 << sz) - 64'd1;
                base = wide ? ({$urandom, $urandom} & ~mask) : ({32'b0, $urandom} & ~mask);
                pos  = int'($urandom % (sz - 5));
                set_win(w, base, mask, {$urandom, $urandom},
                        ($urandom & mask[31:0]) | 32'h1,
                        (w == 2) ? 2'd2 : 2'(1 + ($urandom % 3)),
                        wide, ($urandom % 3) == 0, 5'(pos));
            end
            for (int k = 0; k < 8; k++) tbl_write(int'($urandom % 64), $urandom);
            for (int n = 0; n < 50; n++) begin
                int j;
                j = int'($urandom % NW);
                if ($urandom % 5 == 0) a = {$urandom, $urandom};
                else a = (sb_wide[j] ? sb_base[j] : {32'b0, sb_base[j][31:0]})
                         | ({$urandom, $urandom} & (sb_wide[j] ? sb_mask[j] : {32'b0, sb_mask[j][31:0]}));
                do_req(a, "R3 R5 R7 R10 random");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule